// File: doc/BRIEF.md
# Inter-Processor Event Mailbox

This block is a small memory-mapped synchronization peripheral for a processor subsystem's local bus. A producer on another subsystem first places data in a shared buffer. It then posts an event on one of several independent channels. The mailbox latches the event as a pending flag and raises an interrupt line toward the local processor. The local processor reads the pending flags to confirm which channels have data waiting, fetches the data, and then acknowledges each channel with a write.

Each channel keeps two synchronization flags:

- A pending flag, written on behalf of the remote producer.
- An acknowledged flag, which records that the local consumer has taken the event. A producer can poll this flag to learn that its buffer is free again.

Events can be posted in two ways: by a bus write to the posting register, or through direct per-channel strobe inputs. The bus port is a single-cycle port. Writes take effect at the clock edge that samples them. Read data is combinational while a read strobe is high.

Top module: `mbx_ipc`

## Requirements
- R1: After reset, every pending flag and every acknowledged flag is 0, the mask holds all ones, and `irq` is low.
- R2: Writing a word with bit k set to the post register (word offset 0x0 in the window) sets pending flag k at that clock edge. A 1 on `evt_post[k]` has the same effect. Zero bits leave their channels unchanged.
- R3: A read of the status register (word offset 0x4) returns the pending flags in bits [N-1:0], with all higher bits 0. Writes to this offset change nothing.
- R4: Writing a word with bit k set to the acknowledge register (offset 0x8) clears pending flag k if it was set. In the same edge it sets acknowledged flag k.
- R5: If channel k is posted and acknowledged in the same cycle, the post wins. The pending flag ends at 1 and the acknowledged flag ends at 0.
- R6: The mask register (offset 0xC) is readable and writable in bits [N-1:0], and its higher bits read 0. `irq` is high exactly when some channel is both pending and unmasked.
- R7: `irq` goes low in the cycle right after the edge that clears the last unmasked pending flag.
- R8: Inside the 1 KB window, reads of unused offsets (0x14 and above) return 0, and writes to them change nothing. Accesses whose address lies outside the window change nothing and read as 0.
- R9: The acknowledged register (offset 0x10) returns the acknowledged flags. Posting an event on channel k clears acknowledged flag k. Acknowledging a channel that is not pending leaves both of its flags unchanged.
- R10: The post and acknowledge registers are write-only, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (24) | Local bus byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| evt_post | input | N (8) | Direct per-channel event strobes from the remote side |
| bus_rdata | output | DATA_W (32) | Read data, 0 when no read hits the window |
| irq | output | 1 | Interrupt request toward the local processor |

## Verification
The posting path is exercised three ways: by a bus write with several bits set, by a bus write with no bits set, and through the direct strobes. Together these show that only the written ones take effect.

The acknowledge path is tried on a partly pending set of channels and then on the last remaining one. This shows the difference between a partial clear, which keeps `irq` high, and a final clear, after which `irq` falls one edge later.

A post and an acknowledge are driven onto the same channel in the same cycle to establish the winning side. A later post on an already acknowledged channel shows that its acknowledged flag is reset.

Writes to the status offset, to unused offsets and to an address just past the window are each followed by reads of the state they could have disturbed.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_POST,
    REG_STATUS,
    REG_ACK,
    REG_MASK,
    REG_ACKED
  } reg_sel_e;

  // Word indexes inside the window (byte offset / 4)
  localparam int unsigned WORD_POST   = 0;
  localparam int unsigned WORD_STATUS = 1;
  localparam int unsigned WORD_ACK    = 2;
  localparam int unsigned WORD_MASK   = 3;
  localparam int unsigned WORD_ACKED  = 4;

  function automatic reg_sel_e word_to_sel(input logic [15:0] word);
    reg_sel_e s;
    case (word)
      16'(WORD_POST):   s = REG_POST;
      16'(WORD_STATUS): s = REG_STATUS;
      16'(WORD_ACK):    s = REG_ACK;
      16'(WORD_MASK):   s = REG_MASK;
      16'(WORD_ACKED):  s = REG_ACKED;
      default:          s = REG_NONE;
    endcase
    return s;
  endfunction

  // Next value of one channel's {pending, acked} pair.
  // Posting dominates acknowledging; an acknowledge only counts when pending.
  function automatic logic [1:0] chan_next(input logic post, input logic ack,
                                           input logic pend, input logic acked);
    logic [1:0] nxt;
    if (post)             nxt = 2'b10;
    else if (ack && pend) nxt = 2'b01;
    else                  nxt = {pend, acked};
    return nxt;
  endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned WIN_BITS = 10,
  parameter logic [ADDR_W-1:0] BASE = 24'h300800
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              hit,
  output reg_sel_e          sel,
  output logic              wr_post,
  output logic              wr_ack,
  output logic              wr_mask,
  output logic              rd_en
);
  localparam int unsigned IDX_W = WIN_BITS - 2;

  logic [IDX_W-1:0] word_idx;
  logic             unused_lo;

  assign unused_lo = ^addr[1:0];
  assign word_idx  = addr[WIN_BITS-1:2];
  assign hit       = (addr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);

  always_comb begin
    if (hit) sel = word_to_sel(16'(word_idx));
    else     sel = REG_NONE;
  end

  assign wr_post = wr && (sel == REG_POST);
  assign wr_ack  = wr && (sel == REG_ACK);
  assign wr_mask = wr && (sel == REG_MASK);
  assign rd_en   = rd && hit;

endmodule

// File: rtl/mbx_chan_bank.sv
module mbx_chan_bank
  import mbx_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] post_vec,
  input  logic [N-1:0] ack_vec,
  output logic [N-1:0] pending,
  output logic [N-1:0] acked
);
  for (genvar k = 0; k < N; k++) begin : g_chan
    logic [1:0] nxt;
    assign nxt = chan_next(post_vec[k], ack_vec[k], pending[k], acked[k]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[k] <= 1'b0;
        acked[k]   <= 1'b0;
      end else begin
        pending[k] <= nxt[1];
        acked[k]   <= nxt[0];
      end
    end
  end

endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] MASK_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic [N-1:0] pending,
  output logic [N-1:0] mask_q,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RST;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign irq = |(pending & mask_q);

endmodule

// File: rtl/mbx_ipc.sv
module mbx_ipc
  import mbx_pkg::*;
#(
  parameter int unsigned N        = 8,
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WIN_BITS = 10,
  parameter logic [ADDR_W-1:0] BASE = 24'h300800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N-1:0]      evt_post,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic          hit;
  reg_sel_e      sel;
  logic          wr_post, wr_ack, wr_mask, rd_en;
  logic [N-1:0]  post_vec, ack_vec;
  logic [N-1:0]  pending, acked, mask_q;
  logic [N-1:0]  wfield;
  logic          unused_wd;

  assign wfield    = bus_wdata[N-1:0];
  assign unused_wd = ^bus_wdata[DATA_W-1:N];

  mbx_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE(BASE)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .hit(hit), .sel(sel),
    .wr_post(wr_post), .wr_ack(wr_ack), .wr_mask(wr_mask), .rd_en(rd_en)
  );

  assign post_vec = (wr_post ? wfield : '0) | evt_post;
  assign ack_vec  = wr_ack ? wfield : '0;

  mbx_chan_bank #(.N(N)) u_bank (
    .clk(clk), .rst_n(rst_n), .post_vec(post_vec), .ack_vec(ack_vec),
    .pending(pending), .acked(acked)
  );

  mbx_irq_gen #(.N(N)) u_irq (
    .clk(clk), .rst_n(rst_n), .mask_we(wr_mask), .mask_wdata(wfield),
    .pending(pending), .mask_q(mask_q), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (sel)
        REG_STATUS: bus_rdata = DATA_W'(pending);
        REG_MASK:   bus_rdata = DATA_W'(mask_q);
        REG_ACKED:  bus_rdata = DATA_W'(acked);
        default:    bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mbx_ipc_chk.sv
module mbx_ipc_chk #(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              hit_any,
  input logic [N-1:0]      post_vec,
  input logic [N-1:0]      ack_vec,
  input logic [N-1:0]      pending,
  input logic [N-1:0]      acked,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      evt_post,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq
);
  // R2
  post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|post_vec) |=> ((pending & $past(post_vec)) == $past(post_vec)));

  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_vec & ~post_vec)) |=> ((pending & $past(ack_vec & ~post_vec)) == '0));

  // R5
  post_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_vec & post_vec)) |=> ((acked & $past(ack_vec & post_vec)) == '0));

  // R9
  acked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_vec & pending & ~post_vec))
      |=> ((acked & $past(ack_vec & pending & ~post_vec)) == $past(ack_vec & pending & ~post_vec)));

  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> !irq);

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & mask_q) == '0) |-> !irq);

  // R8
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_any && evt_post == '0)
      |=> (pending == $past(pending) && mask_q == $past(mask_q) && acked == $past(acked)));

  // R8
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || !hit_any) |-> (bus_rdata == '0));

endmodule

bind mbx_ipc mbx_ipc_chk #(.N(N), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .hit_any(hit),
  .post_vec(post_vec), .ack_vec(ack_vec), .pending(pending), .acked(acked),
  .mask_q(mask_q), .evt_post(evt_post), .bus_rdata(bus_rdata), .irq(irq)
);

// File: tb/mbx_ipc_tb.sv
module mbx_ipc_tb;
  localparam int unsigned N = 8;
  localparam logic [23:0] BASE = 24'h300800;
  localparam logic [23:0] O_POST = 24'h0, O_STAT = 24'h4, O_ACK = 24'h8,
                          O_MASK = 24'hC, O_ACKD = 24'h10, O_FREE = 24'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  evt_post = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // bench-side model of the channel flags
  logic [7:0] m_pend = '0, m_ackd = '0, m_mask = 8'hFF;

  always #4 clk = ~clk;

  mbx_ipc u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .evt_post(evt_post), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: pops expected read data mid-cycle
  always @(negedge clk) begin
    if (bus_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  // model update for one captured cycle
  task automatic model_step(input logic [7:0] post, input logic [7:0] ack);
    logic [7:0] won;
    won    = ack & m_pend & ~post;
    m_ackd = (m_ackd & ~post) | won;
    m_pend = (m_pend | post) & ~won;
  endtask

  task automatic drive(input logic [23:0] off, input logic wr, input logic rd,
                       input logic [31:0] d, input logic [7:0] ev);
    @(posedge clk); #1;
    bus_addr = BASE + off; bus_wr = wr; bus_rd = rd; bus_wdata = d; evt_post = ev;
  endtask

  task automatic idle();
    drive(24'h0, 1'b0, 1'b0, 32'h0, 8'h0);
  endtask

  task automatic wr_reg(input logic [23:0] off, input logic [31:0] d, input logic [7:0] ev);
    drive(off, 1'b1, 1'b0, d, ev);
    if (off == O_POST)      model_step(d[7:0] | ev, 8'h0);
    else if (off == O_ACK)  model_step(ev, d[7:0]);
    else begin
      if (off == O_MASK) m_mask = d[7:0];
      model_step(ev, 8'h0);
    end
  endtask

  task automatic rd_reg(input logic [23:0] off, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    drive(off, 1'b0, 1'b1, 32'h0, 8'h0);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd_reg(O_STAT, 32'h0, "R1 status after reset");
    rd_reg(O_MASK, 32'hFF, "R1 mask after reset");
    rd_reg(O_ACKD, 32'h0, "R1 acked after reset");

    // R2 post by bus, several bits
    wr_reg(O_POST, 32'h05, 8'h0);
    idle();
    chk_irq(1'b1, "R6 irq with pending");
    rd_reg(O_STAT, {24'h0, m_pend}, "R2 R3 status after post 0x05");
    wr_reg(O_POST, 32'h0, 8'h0);
    rd_reg(O_STAT, {24'h0, m_pend}, "R2 zero post no effect");
    wr_reg(O_POST, 32'hFFFF_FF80, 8'h0);
    rd_reg(O_STAT, {24'h0, m_pend}, "R2 R3 status after post 0x80, upper bits zero");

    // R10 write-only registers read zero
    rd_reg(O_POST, 32'h0, "R10 post reads zero");
    rd_reg(O_ACK, 32'h0, "R10 ack reads zero");

    // R3 write to status ignored
    wr_reg(O_STAT, 32'h0000_00FF, 8'h0);
    rd_reg(O_STAT, {24'h0, m_pend}, "R3 status write ignored");

    // R6 masking
    wr_reg(O_MASK, 32'hFFFF_FF00, 8'h0);
    idle();
    chk_irq(1'b0, "R6 irq all masked");
    rd_reg(O_MASK, 32'h0, "R6 mask readback upper zero");
    wr_reg(O_MASK, 32'h0000_0004, 8'h0);
    idle();
    chk_irq(1'b1, "R6 irq one channel unmasked");
    wr_reg(O_MASK, 32'hFF, 8'h0);

    // R4 partial acknowledge
    wr_reg(O_ACK, 32'h05, 8'h0);
    idle();
    chk_irq(1'b1, "R7 irq stays with one pending");
    rd_reg(O_STAT, {24'h0, m_pend}, "R4 status after ack 0x05");
    rd_reg(O_ACKD, {24'h0, m_ackd}, "R4 R9 acked after ack 0x05");

    // R7 last clear
    wr_reg(O_ACK, 32'h80, 8'h0);
    chk_irq(1'b1, "R7 irq before clearing edge");
    idle();
    chk_irq(1'b0, "R7 irq low cycle after last clear");
    rd_reg(O_ACKD, {24'h0, m_ackd}, "R4 acked 0x85");

    // R9 ack of idle channel no effect
    wr_reg(O_ACK, 32'h40, 8'h0);
    rd_reg(O_ACKD, {24'h0, m_ackd}, "R9 ack idle channel leaves acked");
    rd_reg(O_STAT, {24'h0, m_pend}, "R9 ack idle channel leaves status");

    // R2 direct strobe
    wr_reg(O_FREE, 32'h0, 8'h02);
    idle();
    chk_irq(1'b1, "R2 irq from strobe");
    rd_reg(O_STAT, 32'h02, "R2 strobe posts channel 1");

    // R5 collision on channel 1
    wr_reg(O_ACK, 32'h02, 8'h02);
    rd_reg(O_STAT, 32'h02, "R5 post wins pending");
    rd_reg(O_ACKD, {24'h0, m_ackd}, "R5 post wins acked");

    // R9 posting clears acked
    wr_reg(O_POST, 32'h01, 8'h0);
    rd_reg(O_ACKD, {24'h0, m_ackd}, "R9 post clears acked bit 0");
    rd_reg(O_ACKD, 32'h84, "R9 acked literal 0x84");

    // R8 unused offset and outside window
    wr_reg(O_FREE, 32'hFF, 8'h0);
    rd_reg(O_FREE, 32'h0, "R8 unused offset reads zero");
    wr_reg(24'h3F8, 32'hFF, 8'h0);
    rd_reg(O_STAT, {24'h0, m_pend}, "R8 unused writes ignored");
    wr_reg(24'h400, 32'hFF, 8'h0);
    rd_reg(O_STAT, {24'h0, m_pend}, "R8 outside-window post ignored");
    rd_reg(24'h404, 32'h0, "R8 outside-window read zero");
    rd_reg(O_MASK, 32'hFF, "R8 mask untouched");

    idle();
    idle();
    if (exp_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL R8 pending reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule